// File: doc/BRIEF.md
# AXI4 Write Burst Master

This block turns one write command into one complete AXI4 write burst. A command gives a start address, an 8-bit length field, a transfer size code and a burst type code. Once the block accepts a command, it presents the address phase on the write address channel. At the same time it pulls beats from a local valid/ready stream and forwards them, with their byte strobes, on the write data channel. It flags the final beat, then waits for the slave's write response. The response code is reported on a one-cycle completion pulse.

Only one burst is in flight at a time. The command port accepts nothing until the response for the current burst has arrived. The block raises its address and data valids without first waiting for the slave's ready signals. The address and control fields are passed through unchanged, so the slave computes the beat addresses. The block keeps no address arithmetic of its own.

Top module: `axi_wburst_master`

## Requirements
- R1: While `rst_n` is low, `aw_valid`, `w_valid`, `b_ready` and `done` are low. After release, `cmd_ready` is high and no channel is active.
- R2: `cmd_ready` is high only while no burst is in progress. A `cmd_valid` presented during a burst is ignored: it causes no second address phase, and the pending address payload does not change.
- R3: In the cycle after a command handshake, `aw_valid` is high whatever the level of `aw_ready`. `aw_addr`, `aw_len`, `aw_size` and `aw_burst` equal the command's fields. There is exactly one address handshake per burst.
- R4: While `aw_valid` is high and `aw_ready` is low, `aw_valid` stays high and the address payload stays stable. After the address handshake, `aw_valid` is low.
- R5: A burst with length field L carries exactly L+1 data handshakes. Beat k carries the k-th accepted stream word and its strobe, with strobe bit i marking data byte i (bits 8i+7..8i).
- R6: `w_last` is high on the final beat (beat L) and low on every earlier beat. After the final data handshake, `w_valid` is low.
- R7: While `w_valid` is high and `w_ready` is low, `w_valid`, `w_data`, `w_strb` and `w_last` stay stable.
- R8: `b_ready` is high exactly in the cycles after both the address handshake and the final data handshake have occurred, until the response handshake.
- R9: In the cycle after the response handshake, `done` is high for one cycle and `done_resp` holds the 2-bit response. `done_err` is bit 1 of that response (high for codes 2 and 3, low for 0 and 1). `cmd_ready` is high again in that same cycle.
- R10: The stream source is drawn from exactly L+1 times per burst. `src_ready` is low once those beats have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command port idle and able to accept |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_len | input | 8 | Beat count minus one |
| cmd_size | input | 3 | Transfer size code, passed through |
| cmd_burst | input | 2 | Burst type code, passed through |
| src_valid | input | 1 | Stream beat available |
| src_ready | output | 1 | Block takes a stream beat |
| src_data | input | DATA_W | Stream data word |
| src_strb | input | DATA_W/8 | Stream byte enables |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write start address |
| aw_len | output | 8 | Burst length field |
| aw_size | output | 3 | Burst size field |
| aw_burst | output | 2 | Burst type field |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Write data |
| w_strb | output | DATA_W/8 | Write byte strobes |
| w_last | output | 1 | Final beat marker |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| b_resp | input | 2 | Write response code |
| done | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Response code of the completed burst |
| done_err | output | 1 | Completed burst reported an error |

## Verification
On every cycle, the assertions check the channel hold rules: the address and data payloads stay frozen under back-pressure, the data valid falls after the last beat, and the source is not drawn after the burst is fully loaded. They also check that the block is quiet while idle, that the response ready appears only once both other channels are finished, and that the completion pulse lasts one cycle and carries the sampled response. Only the bench's scenarios can show the properties that need a count or a reference value. These are the exact number of beats for a given length, the order and content of the data and strobes, a `w_last` that appears on beat L and nowhere else, and the decoded error flag. The bench sweeps lengths from 0 to 255 under steady, random and stalling ready patterns, with all four response codes.

// File: rtl/axi_wb_pkg.sv
package axi_wb_pkg;

  localparam int LEN_W        = 8;
  localparam int SIZE_W       = 3;
  localparam int BURST_W      = 2;
  localparam int RESP_W       = 2;
  localparam int RESP_ERR_BIT = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wb_state_e;

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    logic [SIZE_W-1:0]  size;
    logic [BURST_W-1:0] burst;
  } burst_ctl_t;

endpackage

// File: rtl/axi_wb_addr_ch.sv
module axi_wb_addr_ch
  import axi_wb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  burst_ctl_t        cmd_ctl,
  input  logic              aw_ready,
  output logic              aw_valid,
  output logic [ADDR_W-1:0] aw_addr,
  output burst_ctl_t        aw_ctl,
  output logic              aw_sent
);

  logic              valid_q, valid_d;
  logic              sent_q, sent_d;
  logic [ADDR_W-1:0] addr_q;
  burst_ctl_t        ctl_q;
  logic              fire;

  assign fire = valid_q && aw_ready;

  always_comb begin
    valid_d = valid_q;
    sent_d  = sent_q;
    if (start) begin
      valid_d = 1'b1;
      sent_d  = 1'b0;
    end else if (fire) begin
      valid_d = 1'b0;
      sent_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      sent_q  <= sent_d;
    end
  end

  // payload captured only on command acceptance (clock enable = start)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctl_q  <= '0;
    end else if (start) begin
      addr_q <= cmd_addr;
      ctl_q  <= cmd_ctl;
    end
  end

  assign aw_valid = valid_q;
  assign aw_addr  = addr_q;
  assign aw_ctl   = ctl_q;
  assign aw_sent  = sent_q;

  a_r3_aw_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> aw_valid);

  a_r4_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr) && $stable(aw_ctl)));

  a_r4_aw_once: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> !aw_valid);

endmodule

// File: rtl/axi_wb_data_ch.sv
module axi_wb_data_ch
  import axi_wb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic                src_valid,
  output logic                src_ready,
  input  logic [DATA_W-1:0]   src_data,
  input  logic [DATA_W/8-1:0] src_strb,
  output logic                w_valid,
  input  logic                w_ready,
  output logic [DATA_W-1:0]   w_data,
  output logic [DATA_W/8-1:0] w_strb,
  output logic                w_last,
  output logic                w_sent
);

  localparam int STRB_W = DATA_W / 8;
  localparam int CNT_W  = LEN_W + 1;

  logic [CNT_W-1:0]  left_q, left_d;
  logic              valid_q, valid_d;
  logic              last_q, last_d;
  logic              sent_q, sent_d;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              load, fire;

  assign fire      = valid_q && w_ready;
  assign src_ready = (left_q != '0) && (!valid_q || w_ready);
  assign load      = src_valid && src_ready;

  always_comb begin
    left_d  = left_q;
    valid_d = valid_q;
    last_d  = last_q;
    sent_d  = sent_q;
    if (start) begin
      left_d = {1'b0, cmd_len} + CNT_W'(1);
      sent_d = 1'b0;
    end else begin
      if (load) begin
        left_d  = left_q - CNT_W'(1);
        valid_d = 1'b1;
        last_d  = (left_q == CNT_W'(1));
      end else if (fire) begin
        valid_d = 1'b0;
      end
      if (fire && last_q) begin
        sent_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      left_q  <= left_d;
      valid_q <= valid_d;
      last_q  <= last_d;
      sent_q  <= sent_d;
    end
  end

  // beat payload register, enabled by a stream transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      strb_q <= '0;
    end else if (load) begin
      data_q <= src_data;
      strb_q <= src_strb;
    end
  end

  assign w_valid = valid_q;
  assign w_data  = data_q;
  assign w_strb  = strb_q;
  assign w_last  = last_q;
  assign w_sent  = sent_q;

  a_r7_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && !w_ready) |=>
      (w_valid && $stable(w_data) && $stable(w_strb) && $stable(w_last)));

  a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready && w_last) |=> !w_valid);

  a_r6_last_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_last) |-> !src_ready);

  a_r10_no_overdraw: assert property (@(posedge clk) disable iff (!rst_n)
    w_sent |-> !src_ready);

endmodule

// File: rtl/axi_wb_resp_ch.sv
module axi_wb_resp_ch
  import axi_wb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              aw_sent,
  input  logic              w_sent,
  input  logic              b_valid,
  input  logic [RESP_W-1:0] b_resp,
  output logic              b_ready,
  output logic              finish,
  output logic              done,
  output logic [RESP_W-1:0] done_resp,
  output logic              done_err
);

  logic              wait_q, wait_d;
  logic              done_q;
  logic [RESP_W-1:0] resp_q;

  assign b_ready = wait_q && aw_sent && w_sent;
  assign finish  = b_valid && b_ready;

  always_comb begin
    wait_d = wait_q;
    if (start) begin
      wait_d = 1'b1;
    end else if (finish) begin
      wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
    end else if (finish) begin
      resp_q <= b_resp;
    end
  end

  assign done      = done_q;
  assign done_resp = resp_q;
  assign done_err  = resp_q[RESP_ERR_BIT];

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_resp: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && (done_resp == $past(b_resp))));

  a_r8_bready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ready && !b_valid) |=> b_ready);

endmodule

// File: rtl/axi_wburst_master.sv
module axi_wburst_master
  import axi_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [7:0]          cmd_len,
  input  logic [2:0]          cmd_size,
  input  logic [1:0]          cmd_burst,
  input  logic                src_valid,
  output logic                src_ready,
  input  logic [DATA_W-1:0]   src_data,
  input  logic [DATA_W/8-1:0] src_strb,
  output logic                aw_valid,
  input  logic                aw_ready,
  output logic [ADDR_W-1:0]   aw_addr,
  output logic [7:0]          aw_len,
  output logic [2:0]          aw_size,
  output logic [1:0]          aw_burst,
  output logic                w_valid,
  input  logic                w_ready,
  output logic [DATA_W-1:0]   w_data,
  output logic [DATA_W/8-1:0] w_strb,
  output logic                w_last,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic [1:0]          b_resp,
  output logic                done,
  output logic [1:0]          done_resp,
  output logic                done_err
);

  wb_state_e  state_q, state_d;
  logic       start, finish;
  logic       aw_sent, w_sent;
  burst_ctl_t cmd_ctl, aw_ctl;

  assign cmd_ready = (state_q == ST_IDLE);
  assign start     = cmd_valid && cmd_ready;

  assign cmd_ctl.len   = cmd_len;
  assign cmd_ctl.size  = cmd_size;
  assign cmd_ctl.burst = cmd_burst;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)  state_d = ST_RUN;
      ST_RUN:  if (finish) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  axi_wb_addr_ch #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_addr (cmd_addr),
    .cmd_ctl  (cmd_ctl),
    .aw_ready (aw_ready),
    .aw_valid (aw_valid),
    .aw_addr  (aw_addr),
    .aw_ctl   (aw_ctl),
    .aw_sent  (aw_sent)
  );

  assign aw_len   = aw_ctl.len;
  assign aw_size  = aw_ctl.size;
  assign aw_burst = aw_ctl.burst;

  axi_wb_data_ch #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_len   (cmd_len),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .src_strb  (src_strb),
    .w_valid   (w_valid),
    .w_ready   (w_ready),
    .w_data    (w_data),
    .w_strb    (w_strb),
    .w_last    (w_last),
    .w_sent    (w_sent)
  );

  axi_wb_resp_ch u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .aw_sent   (aw_sent),
    .w_sent    (w_sent),
    .b_valid   (b_valid),
    .b_resp    (b_resp),
    .b_ready   (b_ready),
    .finish    (finish),
    .done      (done),
    .done_resp (done_resp),
    .done_err  (done_err)
  );

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!aw_valid && !w_valid && !b_ready));

  a_r8_b_after_all: assert property (@(posedge clk) disable iff (!rst_n)
    b_ready |-> (!aw_valid && !w_valid));

endmodule

// File: tb/axi_wburst_master_tb.sv
module axi_wburst_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0;
  logic [2:0]  cmd_size = '0;
  logic [1:0]  cmd_burst = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [31:0] src_data = '0;
  logic [3:0]  src_strb = '0;
  logic        aw_valid, aw_ready = 1'b0;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst;
  logic        w_valid, w_ready = 1'b0;
  logic [31:0] w_data;
  logic [3:0]  w_strb;
  logic        w_last;
  logic        b_valid = 1'b0, b_ready;
  logic [1:0]  b_resp = '0;
  logic        done, done_err;
  logic [1:0]  done_resp;

  always #4 clk = ~clk;

  axi_wburst_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .src_strb(src_strb),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .done(done), .done_resp(done_resp), .done_err(done_err)
  );

  int n_checks = 0;
  int n_fail = 0;

  // expected burst context
  int          pat = 0;
  int          bno = 0;
  logic [31:0] e_addr = '0;
  logic [7:0]  e_len = '0;
  logic [2:0]  e_size = '0;
  logic [1:0]  e_burst = '0;
  logic [1:0]  e_resp = '0;

  // monitor state
  bit   busy_m = 0, acc_prev = 0, b_seen_d = 0, b_seen_d2 = 0, full_m = 0;
  int   aw_cnt = 0, w_cnt = 0, s_cnt = 0, done_cnt = 0, cyc = 0;
  bit   p_awv = 0, p_awr = 0, p_wv = 0, p_wr = 0, p_wl = 0;
  logic [31:0] p_addr = '0, p_wdata = '0;
  logic [3:0]  p_wstrb = '0;
  logic [15:0] lfsr = 16'hACE1;
  int   bdly = 0;

  function automatic logic [31:0] fdat(int b, int i);
    return {8'(b), 8'(i) ^ 8'h3C, 16'(i * 7 + b * 3)};
  endfunction

  function automatic logic [3:0] fstrb(int b, int i);
    return 4'(i + b * 5);
  endfunction

  // channel enable per pattern: which 0=aw_ready 1=w_ready 2=src_valid
  function automatic bit gen(int p, int which, int c, logic [15:0] r);
    case (p)
      0: return 1'b1;
      1: return r[which * 3];
      2: return (which == 0) ? ((c % 7) == 6) : ((c % 4) != 3);
      default: return (which == 2) ? ((c % 3) == 0) : ((c % 2) == 1);
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (burst %0d)", tag, act, exp, bno);
    end
  endtask

  // stimulus for slave readiness, stream source and response
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    aw_ready <= gen(pat, 0, cyc, lfsr);
    w_ready  <= gen(pat, 1, cyc, lfsr);
    src_valid <= gen(pat, 2, cyc, lfsr);
    src_data <= fdat(bno, s_cnt);
    src_strb <= fstrb(bno, s_cnt);
    if (b_seen_d) begin
      b_valid <= 1'b0;
      bdly <= 0;
    end else if (busy_m && full_m) begin
      if (bdly >= pat) begin
        b_valid <= 1'b1;
        b_resp  <= e_resp;
      end
      bdly <= bdly + 1;
    end
  end

  // monitor: inputs settle at posedge+1, so values at negedge hold to the next edge
  always @(negedge clk) begin
    bit f_aw, f_w, f_s, f_b, f_cmd;
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
    if (rst_n) begin
      f_aw  = aw_valid && aw_ready;
      f_w   = w_valid && w_ready;
      f_s   = src_valid && src_ready;
      f_b   = b_valid && b_ready;
      f_cmd = cmd_valid && cmd_ready;
      full_m = (aw_cnt == 1) && (w_cnt == int'(e_len) + 1);

      if (acc_prev) begin
        chk(aw_valid == 1'b1, "R3 aw_valid after accept", 64'(aw_valid), 64'd1);
        chk(aw_addr == e_addr && aw_len == e_len && aw_size == e_size && aw_burst == e_burst,
            "R3 aw payload", {aw_addr, 19'd0, aw_len, aw_size, aw_burst},
            {e_addr, 19'd0, e_len, e_size, e_burst});
      end
      if (p_awv && !p_awr)
        chk(aw_valid && aw_addr == p_addr, "R4 aw hold", 64'(aw_addr), 64'(p_addr));
      if (busy_m && aw_cnt == 1)
        chk(!aw_valid, "R4 aw dropped after handshake", 64'(aw_valid), 64'd0);
      if (p_wv && !p_wr)
        chk(w_valid && w_data == p_wdata && w_strb == p_wstrb && w_last == p_wl,
            "R7 w hold", {w_strb, w_data}, {p_wstrb, p_wdata});
      if (busy_m)
        chk(!cmd_ready, "R2 cmd_ready low while busy", 64'(cmd_ready), 64'd0);
      if (b_ready)
        chk(full_m, "R8 b_ready before channels done", {32'(aw_cnt), 32'(w_cnt)},
            {32'd1, 32'(int'(e_len) + 1)});
      if (busy_m && full_m)
        chk(b_ready, "R8 b_ready held while awaiting", 64'(b_ready), 64'd1);
      if (busy_m && w_cnt == int'(e_len) + 1)
        chk(!w_valid, "R6 w_valid low after final beat", 64'(w_valid), 64'd0);
      if (busy_m && s_cnt == int'(e_len) + 1 && src_valid)
        chk(!src_ready, "R10 src_ready low after last draw", 64'(src_ready), 64'd0);
      if (b_seen_d)
        chk(done && done_resp == e_resp && done_err == e_resp[1] && cmd_ready,
            "R9 done report", {done, done_resp, done_err, cmd_ready},
            {1'b1, e_resp, e_resp[1], 1'b1});
      if (b_seen_d2)
        chk(!done, "R9 done single pulse", 64'(done), 64'd0);
      if (f_w) begin
        chk(w_cnt <= int'(e_len), "R5 beat count", 64'(w_cnt), 64'(e_len));
        chk(w_data == fdat(bno, w_cnt) && w_strb == fstrb(bno, w_cnt), "R5 beat data/strobe",
            {w_strb, w_data}, {fstrb(bno, w_cnt), fdat(bno, w_cnt)});
        chk(w_last == (w_cnt == int'(e_len)), "R6 w_last position", 64'(w_last),
            64'(w_cnt == int'(e_len)));
      end
      if (f_s)
        chk(s_cnt <= int'(e_len), "R10 source overdraw", 64'(s_cnt), 64'(e_len));
      if (f_aw)
        chk(aw_cnt == 0, "R3 single address phase", 64'(aw_cnt + 1), 64'd1);

      // state updates for handshakes at the coming edge
      b_seen_d2 = b_seen_d;
      b_seen_d  = f_b;
      acc_prev  = f_cmd;
      p_awv = aw_valid; p_awr = aw_ready; p_addr = aw_addr;
      p_wv = w_valid; p_wr = w_ready; p_wdata = w_data; p_wstrb = w_strb; p_wl = w_last;
      if (f_aw) aw_cnt++;
      if (f_w)  w_cnt++;
      if (f_s)  s_cnt++;
      if (f_b) begin
        busy_m = 0;
        done_cnt++;
      end
      if (f_cmd) begin
        busy_m = 1;
        aw_cnt = 0; w_cnt = 0; s_cnt = 0;
      end
    end else begin
      chk(!aw_valid && !w_valid && !b_ready && !done, "R1 reset quiet",
          {aw_valid, w_valid, b_ready, done}, 64'd0);
    end
  end

  task automatic run_burst(logic [31:0] a, logic [7:0] l, logic [2:0] s, logic [1:0] bt,
                           logic [1:0] r, bit junk);
    int target;
    target = done_cnt + 1;
    @(posedge clk); #1;
    e_addr = a; e_len = l; e_size = s; e_burst = bt; e_resp = r;
    cmd_addr = a; cmd_len = l; cmd_size = s; cmd_burst = bt; cmd_valid = 1'b1;
    do @(negedge clk); while (!(cmd_valid && cmd_ready));
    @(posedge clk); #1;
    if (junk) begin
      // R2: a command offered mid-burst must be ignored
      cmd_addr = 32'hDEAD_BEE0; cmd_len = 8'hAA; cmd_size = 3'd7; cmd_burst = 2'd3;
      do @(negedge clk); while (!full_m);
      @(posedge clk); #1;
    end
    cmd_valid = 1'b0;
    do @(negedge clk); while (done_cnt < target);
    @(negedge clk);
    @(negedge clk);
    chk(aw_cnt == 1 && w_cnt == int'(l) + 1 && s_cnt == int'(l) + 1,
        "R5 R10 totals per burst", {16'(aw_cnt), 16'(w_cnt), 16'(s_cnt)},
        {16'd1, 16'(int'(l) + 1), 16'(int'(l) + 1)});
    bno++;
  endtask

  initial begin
    int lens[7] = '{0, 1, 2, 3, 5, 15, 255};
    repeat (4) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);
    for (int p = 0; p < 4; p++) begin
      pat = p;
      for (int i = 0; i < 7; i++) begin
        run_burst(32'h1000_0004 + 32'(bno) * 32'h100, 8'(lens[i]), 3'(bno % 3),
                  2'(bno % 3), 2'(bno % 4), bno[0]);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule